// File: doc/BRIEF.md
# Retransmit FIFO with Status Flags

A first-in/first-out store of nine-bit words held in a dual-port memory. Writers and readers never supply an address. Each side has its own pointer, and that pointer moves on by one every time an operation is accepted. Words come out in the order they went in. The ninth bit behaves like every other bit, so it can carry a parity bit or a tag.

The strobes and the other controls are active low. Each one is sampled on a single clock, and an operation starts on the high-to-low transition of its strobe. Three flags report the fill level: empty, full and more-than-half. A rewind operation returns the read pointer to location zero, so the buffered data can be read a second time. The write pointer and the stored words are left alone. With the expansion input tied low, the block runs as a single device. In that mode the shared control input performs rewind and the shared output presents the half-full flag.

Top module: `rtx_fifo`

## Requirements
- R1: Words are 9 bits wide, and all nine bits, bit 8 included, come back unchanged and in write order.
- R2: The parameter DEPTH selects 256, 512 or 1024 words. The full and half-full thresholds follow DEPTH.
- R3: When the buffer is neither empty nor full, a read and a write started on the same clock are both performed.
- R4: A strobe acts once per high-to-low transition as sampled on clk. Holding it low for more cycles starts nothing further.
- R5: Driving rst_n low (asynchronous) empties the buffer, sets both pointers to location 0, clears dout to 0 and drives empty_n low.
- R6: empty_n is low exactly when 0 words are stored, and full_n is low exactly when DEPTH words are stored. Both change on the clock edge that performs the operation.
- R7: With exp_in low, exp_hf_n is low while more than DEPTH/2 words are stored and high at DEPTH/2 words or fewer.
- R8: A write while full and a read while empty are ignored. No pointer moves, dout holds its value and no stored word changes.
- R9: A simultaneous read and write on an empty buffer performs only the write. On a full buffer it performs only the read.
- R10: With exp_in low, a falling edge on ld_rt_n moves the read pointer to location 0 and keeps the write pointer and the data. Read and write strobes that start on that same clock are ignored.
- R11: With exp_in high, ld_rt_n has no effect and exp_hf_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 9 | Write data |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ld_rt_n | input | 1 | First-load / rewind control, active low |
| exp_in | input | 1 | Expansion input; low selects single-device mode |
| dout | output | 9 | Last word read |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| exp_hf_n | output | 1 | Half-full flag in single-device mode, active low |

## Verification
The hardest state to reach is a full buffer that receives a read and a write in the same cycle. The bench gets there by filling all 256 words with a computed pattern and then pulsing both strobes together. It then drains the buffer and checks that the late write never appears.

Rewind is driven after a partial drain, so that a correct design visibly replays words that were already read. The 1024-deep copy is pushed just past its midpoint while the shallow copy sits full, which shows that the thresholds follow the parameter.

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             ld_rt_n,
  input  logic             exp_in,
  output logic [WIDTH-1:0] dout,
  output logic             empty_n,
  output logic             full_n,
  output logic             exp_hf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             wr_d, rd_d, rt_d;
  logic             wr_fall, rd_fall, rt_go, do_wr, do_rd;

  assign wr_fall = wr_d & ~wr_n;
  assign rd_fall = rd_d & ~rd_n;
  assign rt_go   = rt_d & ~ld_rt_n & ~exp_in;
  assign do_wr   = wr_fall & (cnt != FULL_CNT) & ~rt_go;
  assign do_rd   = rd_fall & (cnt != '0) & ~rt_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d <= 1'b1;
      rd_d <= 1'b1;
      rt_d <= 1'b1;
    end else begin
      wr_d <= wr_n;
      rd_d <= rd_n;
      rt_d <= ld_rt_n;
    end
  end

  always_ff @(posedge clk)
    if (do_wr) mem[wptr] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      dout <= '0;
    end else if (rt_go) begin
      rptr <= '0;
      if (wptr == '0 && cnt != '0) cnt <= FULL_CNT;
      else                         cnt <= CW'(wptr);
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) begin
        dout <= mem[rptr];
        rptr <= rptr + 1'b1;
      end
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  assign empty_n  = (cnt != '0);
  assign full_n   = (cnt != FULL_CNT);
  assign exp_hf_n = exp_in | ~(cnt > HALF_CNT);

  initial AST_DEPTH_LEGAL: assert (DEPTH == 256 || DEPTH == 512 || DEPTH == 1024); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    empty_n || full_n); // R6
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL_CNT && wr_fall && !rd_fall && !rt_go) |=> (cnt == FULL_CNT && $stable(wptr))); // R8
  AST_EMPTY_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rd_fall && !wr_fall && !rt_go) |=> ($stable(dout) && $stable(rptr))); // R8
  AST_EMPTY_BOTH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && wr_fall && rd_fall && !rt_go) |=> (cnt == CW'(1) && $stable(dout))); // R9
  AST_RT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    rt_go |=> (rptr == '0 && $stable(wptr))); // R10
  AST_XI_HOLDS_HF: assert property (@(posedge clk) disable iff (!rst_n)
    exp_in |-> exp_hf_n); // R11
endmodule

// File: tb/rtx_fifo_bench.sv
module rtx_fifo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] din = '0;
  logic wr_n = 1'b1, rd_n = 1'b1, ld_rt_n = 1'b1, exp_in = 1'b0;
  logic [8:0] dout, dout_deep;
  logic empty_n, full_n, exp_hf_n, empty_n_deep, full_n_deep, exp_hf_n_deep;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rtx_fifo #(.DEPTH(256)) u_rtx_fifo (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_n(wr_n), .rd_n(rd_n),
    .ld_rt_n(ld_rt_n), .exp_in(exp_in), .dout(dout), .empty_n(empty_n),
    .full_n(full_n), .exp_hf_n(exp_hf_n));

  rtx_fifo #(.DEPTH(1024)) u_rtx_fifo_deep (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_n(wr_n), .rd_n(rd_n),
    .ld_rt_n(ld_rt_n), .exp_in(exp_in), .dout(dout_deep), .empty_n(empty_n_deep),
    .full_n(full_n_deep), .exp_hf_n(exp_hf_n_deep));

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe(input logic w, input logic r, input logic t, input logic [8:0] d);
    @(negedge clk);
    din = d; wr_n = ~w; rd_n = ~r; ld_rt_n = ~t;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; ld_rt_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] d); strobe(1'b1, 1'b0, 1'b0, d); endtask
  task automatic rd(); strobe(1'b0, 1'b1, 1'b0, 9'h0); endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; exp_in = 1'b0;
    @(negedge clk);
    chk("R5 empty_n in reset", empty_n, 0);
    chk("R5 dout in reset", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 full_n after reset", full_n, 1);
    chk("R5 exp_hf_n after reset", exp_hf_n, 1);
  endtask

  task automatic t_order();
    t_reset();
    wr(9'h1A5); wr(9'h0FF); wr(9'h100);
    chk("R6 empty_n with data", empty_n, 1);
    rd(); chk("R1 first word", dout, 9'h1A5);
    rd(); chk("R1 second word", dout, 9'h0FF);
    rd(); chk("R1 bit 8 word", dout, 9'h100);
    chk("R6 empty_n drained", empty_n, 0);
    rd();
    chk("R8 read on empty keeps dout", dout, 9'h100);
    chk("R8 read on empty stays empty", empty_n, 0);
  endtask

  task automatic t_hold();
    t_reset();
    @(negedge clk); din = 9'h033; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; @(negedge clk);
    rd(); chk("R4 held strobe word", dout, 9'h033);
    chk("R4 held strobe wrote once", empty_n, 0);
  endtask

  task automatic t_fill();
    t_reset();
    for (int i = 0; i < 128; i++) wr(pat(i));
    chk("R7 hf inactive at half", exp_hf_n, 1);
    wr(pat(128));
    chk("R7 hf active above half", exp_hf_n, 0);
    rd(); chk("R1 fill first word", dout, pat(0));
    chk("R7 hf clears at half", exp_hf_n, 1);
    for (int i = 129; i < 257; i++) wr(pat(i));
    chk("R6 full_n at depth", full_n, 0);
    wr(9'h1FF);
    chk("R8 write on full stays full", full_n, 0);
    for (int i = 1; i < 257; i++) begin
      rd(); chk("R8 drain after full", dout, pat(i));
    end
    chk("R8 extra write not stored", empty_n, 0);
  endtask

  task automatic t_both();
    t_reset();
    strobe(1'b1, 1'b1, 1'b0, 9'h055);
    chk("R9 empty both: write kept", empty_n, 1);
    chk("R9 empty both: no read", dout, 0);
    rd(); chk("R9 empty both: word", dout, 9'h055);
    t_reset();
    for (int i = 0; i < 256; i++) wr(pat(i));
    strobe(1'b1, 1'b1, 1'b0, 9'h1EE);
    chk("R9 full both: read done", dout, pat(0));
    chk("R9 full both: not full", full_n, 1);
    for (int i = 1; i < 256; i++) begin
      rd(); chk("R9 full both drain", dout, pat(i));
    end
    chk("R9 full both: write dropped", empty_n, 0);
    t_reset();
    wr(9'h011); wr(9'h022);
    strobe(1'b1, 1'b1, 1'b0, 9'h133);
    chk("R3 mid both: read", dout, 9'h011);
    rd(); chk("R3 mid both: next", dout, 9'h022);
    rd(); chk("R3 mid both: written", dout, 9'h133);
    chk("R3 mid both: empty", empty_n, 0);
  endtask

  task automatic t_rt();
    t_reset();
    for (int i = 0; i < 5; i++) wr(pat(i + 40));
    rd(); rd(); rd();
    strobe(1'b0, 1'b0, 1'b1, 9'h0);
    for (int i = 0; i < 5; i++) begin
      rd(); chk("R10 replay", dout, pat(i + 40));
    end
    chk("R10 empty after replay", empty_n, 0);
    wr(9'h0AA);
    rd(); chk("R10 write pointer kept", dout, 9'h0AA);
  endtask

  task automatic t_xi();
    t_reset();
    exp_in = 1'b1;
    for (int i = 0; i < 129; i++) wr(pat(i));
    chk("R11 hf held high", exp_hf_n, 1);
    @(negedge clk); exp_in = 1'b0; @(negedge clk);
    chk("R7 hf shown in single mode", exp_hf_n, 0);
    exp_in = 1'b1;
    rd();
    strobe(1'b0, 1'b0, 1'b1, 9'h0);
    rd(); chk("R11 rewind ignored", dout, pat(1));
    exp_in = 1'b0;
  endtask

  task automatic t_deep();
    t_reset();
    for (int i = 0; i < 512; i++) wr(pat(i));
    chk("R2 deep hf at half", exp_hf_n_deep, 1);
    wr(pat(512));
    chk("R2 deep hf above half", exp_hf_n_deep, 0);
    chk("R2 deep not full", full_n_deep, 1);
    chk("R2 shallow full", full_n, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_order();
    t_hold();
    t_fill();
    t_both();
    t_rt();
    t_xi();
    t_deep();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule